// File: doc/BRIEF.md
# Debug Monitor Halt Control Unit

This block is the control and status core of a hardware debug monitor that sits beside a target CPU. Monitor firmware writes an 8-bit control byte that selects trace mode (which holds the target), enables each halt source separately, turns history capture on or off, and masks the target's interrupts. External comparators report address breakpoint hits and data watchpoint hits; the block checks flag breakpoints itself by comparing the target's processor flags against a set-mask and a clear-mask.

The block combines these sources into a single halt request. It also returns an 8-bit status byte that records which enabled source actually stopped the target, mirrors two enable bits, and shows the raw watchpoint input. A step request inverts a toggle output, which the target uses to advance exactly one instruction while it is held.

Top module: `dbg_halt_ctrl`

## Requirements
- R1: When control bit 0 (trace) is 1, `halt_o` is 1 in the same cycle. After the control byte is written with bit 0 clear and no other source active, `halt_o` returns to 0.
- R2: After reset, `ctl_q` reads 0x20 and `status_q` reads 0x00 while all inputs are low.
- R3: A write (`ctl_wr`) loads `ctl_wdata` into `ctl_q` at the next clock edge, but bit 5 always reads 1.
- R4: `halt_o` is the combinational OR of: trace (bit 0); `brk_hit` AND bit 7; `wpt_hit` AND bit 6; flag match AND bit 1. A source whose enable is 0 does not halt.
- R5: A flag match is true when any flag bit selected by the set-mask is 1, or any flag bit selected by the clear-mask is 0. A mask load (`mask_wr`) stores both masks and sets control bit 1 at the same edge.
- R6: Status bits 0, 1 and 2 are set at the next edge when, respectively, an enabled breakpoint, watchpoint or flag match is present. A match whose enable bit is 0 leaves its bit unchanged.
- R7: Status bits 0 to 2 stay set until a control write. The write clears them, unless a qualifying match is present in that same cycle.
- R8: Status bit 3 equals control bit 6 and status bit 4 equals control bit 7. Status bit 5 equals `wpt_hit` in the same cycle, and status bit 6 is always 0.
- R9: `hist_done` clears control bit 2 at the next edge when control bit 3 is 0, and this overrides a write in the same cycle. When control bit 3 is 1, `hist_done` has no effect.
- R10: Each cycle with `step_req` high inverts `step_toggle_o` at the next edge. Status bit 7 carries the same value.
- R11: `irq_inhibit_o`, `hist_en_o`, `hist_cont_o` and `trap_en_o` equal control bits 4, 2, 3 and 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Write strobe for the control byte |
| ctl_wdata | input | 8 | Control byte write value |
| mask_wr | input | 1 | Load strobe for both flag masks |
| mask_set | input | FLAG_W | Flags that trigger when set |
| mask_clr | input | FLAG_W | Flags that trigger when clear |
| cpu_flags | input | FLAG_W | Target processor flags |
| brk_hit | input | 1 | Address breakpoint comparator hit |
| wpt_hit | input | 1 | Data watchpoint comparator hit |
| step_req | input | 1 | Single-step request |
| hist_done | input | 1 | Trace buffer full pulse |
| halt_o | output | 1 | Halt request to the target |
| irq_inhibit_o | output | 1 | Interrupt inhibit to the target |
| trap_en_o | output | 1 | Trap enable (fixed high) |
| hist_en_o | output | 1 | History capture enable |
| hist_cont_o | output | 1 | Continuous history capture |
| step_toggle_o | output | 1 | Single-step toggle |
| ctl_q | output | 8 | Control byte readback |
| status_q | output | 8 | Status byte |

## Verification
The assertions assume every input is a known 0 or 1 and holds steady across the rising edge that samples it. They also assume the match inputs refer to the same cycle as the control byte they are gated with. The stimulus meets this by changing inputs only on the falling edge, using a fixed-seed random mix of strobes, masks and flag patterns. Rare strobes such as control writes, mask loads and `hist_done` are weighted lower so that sticky status bits and history clearing have time to show.

// File: rtl/dbg_mon_pkg.sv
package dbg_mon_pkg;

    localparam int CTL_W = 8;

    // Control byte, most significant field first
    typedef struct packed {
        logic brk_en;
        logic wpt_en;
        logic trap_en;
        logic irq_inh;
        logic hist_cont;
        logic hist_en;
        logic flag_en;
        logic trace;
    } ctl_t;

    // Sticky halt causes
    typedef struct packed {
        logic flag;
        logic wpt;
        logic brk;
    } cause_t;

    localparam ctl_t CTL_RESET = '{trap_en: 1'b1, default: 1'b0};

    function automatic logic [CTL_W-1:0] pack_status(
        input logic   tgl,
        input logic   wpt_raw,
        input ctl_t   c,
        input cause_t k
    );
        return {tgl, 1'b0, wpt_raw, c.brk_en, c.wpt_en, k.flag, k.wpt, k.brk};
    endfunction

endpackage

// File: rtl/dbg_ctl_reg.sv
module dbg_ctl_reg
    import dbg_mon_pkg::*;
#(
    parameter int FLAG_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [CTL_W-1:0]  wdata,
    input  logic              mask_wr,
    input  logic [FLAG_W-1:0] set_in,
    input  logic [FLAG_W-1:0] clr_in,
    input  logic              hist_done,
    output ctl_t              ctl,
    output logic [FLAG_W-1:0] set_q,
    output logic [FLAG_W-1:0] clr_q
);

    ctl_t nxt;

    always_comb begin
        nxt = ctl;
        if (wr)
            nxt = ctl_t'(wdata);
        if (mask_wr)
            nxt.flag_en = 1'b1;
        if (hist_done && !ctl.hist_cont)
            nxt.hist_en = 1'b0;
        nxt.trap_en = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl   <= CTL_RESET;
            set_q <= '0;
            clr_q <= '0;
        end else begin
            ctl <= nxt;
            if (mask_wr) begin
                set_q <= set_in;
                clr_q <= clr_in;
            end
        end
    end

    p_trap_fixed_r3: assert property (@(posedge clk) disable iff (rst)
        wr |=> ctl.trap_en);

    p_mask_enables_r5: assert property (@(posedge clk) disable iff (rst)
        mask_wr |=> ctl.flag_en);

    p_hist_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (hist_done && !ctl.hist_cont) |=> !ctl.hist_en);

    p_hist_cont_keep_r9: assert property (@(posedge clk) disable iff (rst)
        (hist_done && ctl.hist_cont && !wr) |=> $stable(ctl.hist_en));

endmodule

// File: rtl/dbg_flag_match.sv
module dbg_flag_match #(
    parameter int FLAG_W = 8
) (
    input  logic [FLAG_W-1:0] flags,
    input  logic [FLAG_W-1:0] set_m,
    input  logic [FLAG_W-1:0] clr_m,
    output logic              hit
);

    logic [FLAG_W-1:0] bit_hit;

    for (genvar i = 0; i < FLAG_W; i++) begin : g_bit
        assign bit_hit[i] = (flags[i] & set_m[i]) | (~flags[i] & clr_m[i]);
    end

    assign hit = |bit_hit;

endmodule

// File: rtl/dbg_halt_eval.sv
module dbg_halt_eval
    import dbg_mon_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  ctl_t   ctl,
    input  logic   ctl_wr,
    input  logic   brk_in,
    input  logic   wpt_in,
    input  logic   flag_in,
    input  logic   step_req,
    output logic   halt,
    output cause_t cause_q,
    output logic   step_tgl
);

    cause_t cause_now;

    always_comb begin
        cause_now.brk  = brk_in  & ctl.brk_en;
        cause_now.wpt  = wpt_in  & ctl.wpt_en;
        cause_now.flag = flag_in & ctl.flag_en;
        halt = ctl.trace | cause_now.brk | cause_now.wpt | cause_now.flag;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cause_q  <= '0;
            step_tgl <= 1'b0;
        end else begin
            cause_q  <= cause_now | (ctl_wr ? cause_t'('0) : cause_q);
            step_tgl <= step_tgl ^ step_req;
        end
    end

    p_trace_halts_r1: assert property (@(posedge clk) disable iff (rst)
        ctl.trace |-> halt);

    p_all_off_r4: assert property (@(posedge clk) disable iff (rst)
        (!ctl.trace && !ctl.brk_en && !ctl.wpt_en && !ctl.flag_en) |-> !halt);

    p_brk_gated_r6: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && !ctl.brk_en) |=> !cause_q.brk);

    p_brk_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (cause_q.brk && !ctl_wr) |=> cause_q.brk);

    p_step_flip_r10: assert property (@(posedge clk) disable iff (rst)
        step_req |=> (step_tgl != $past(step_tgl)));

endmodule

// File: rtl/dbg_halt_ctrl.sv
module dbg_halt_ctrl
    import dbg_mon_pkg::*;
#(
    parameter int FLAG_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_wr,
    input  logic [7:0]        ctl_wdata,
    input  logic              mask_wr,
    input  logic [FLAG_W-1:0] mask_set,
    input  logic [FLAG_W-1:0] mask_clr,
    input  logic [FLAG_W-1:0] cpu_flags,
    input  logic              brk_hit,
    input  logic              wpt_hit,
    input  logic              step_req,
    input  logic              hist_done,
    output logic              halt_o,
    output logic              irq_inhibit_o,
    output logic              trap_en_o,
    output logic              hist_en_o,
    output logic              hist_cont_o,
    output logic              step_toggle_o,
    output logic [7:0]        ctl_q,
    output logic [7:0]        status_q
);

    ctl_t              ctl;
    cause_t            cause;
    logic [FLAG_W-1:0] set_m;
    logic [FLAG_W-1:0] clr_m;
    logic              flag_hit;
    logic              tgl;

    dbg_ctl_reg #(.FLAG_W(FLAG_W)) u_ctl (
        .clk       (clk),
        .rst       (rst),
        .wr        (ctl_wr),
        .wdata     (ctl_wdata),
        .mask_wr   (mask_wr),
        .set_in    (mask_set),
        .clr_in    (mask_clr),
        .hist_done (hist_done),
        .ctl       (ctl),
        .set_q     (set_m),
        .clr_q     (clr_m)
    );

    dbg_flag_match #(.FLAG_W(FLAG_W)) u_flag (
        .flags (cpu_flags),
        .set_m (set_m),
        .clr_m (clr_m),
        .hit   (flag_hit)
    );

    dbg_halt_eval u_eval (
        .clk      (clk),
        .rst      (rst),
        .ctl      (ctl),
        .ctl_wr   (ctl_wr),
        .brk_in   (brk_hit),
        .wpt_in   (wpt_hit),
        .flag_in  (flag_hit),
        .step_req (step_req),
        .halt     (halt_o),
        .cause_q  (cause),
        .step_tgl (tgl)
    );

    assign ctl_q         = ctl;
    assign status_q      = pack_status(tgl, wpt_hit, ctl, cause);
    assign irq_inhibit_o = ctl.irq_inh;
    assign trap_en_o     = ctl.trap_en;
    assign hist_en_o     = ctl.hist_en;
    assign hist_cont_o   = ctl.hist_cont;
    assign step_toggle_o = tgl;

    p_status_zero_r8: assert property (@(posedge clk) disable iff (rst)
        !status_q[6] && (status_q[5] == wpt_hit));

endmodule

// File: tb/tb_dbg_halt_ctrl.sv
`timescale 1ns/1ps
module tb_dbg_halt_ctrl;

    localparam int FW = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic          ctl_wr, mask_wr, brk_hit, wpt_hit, step_req, hist_done;
    logic [7:0]    ctl_wdata;
    logic [FW-1:0] mask_set, mask_clr, cpu_flags;
    logic          halt_o, irq_inhibit_o, trap_en_o, hist_en_o, hist_cont_o, step_toggle_o;
    logic [7:0]    ctl_q, status_q;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // reference state
    logic [7:0]    mctl;
    logic [FW-1:0] msm, mcm;
    logic          mbs, mws, mfs, mtgl;

    always #2.5 clk = ~clk;

    dbg_halt_ctrl #(.FLAG_W(FW)) dut (
        .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
        .mask_wr(mask_wr), .mask_set(mask_set), .mask_clr(mask_clr),
        .cpu_flags(cpu_flags), .brk_hit(brk_hit), .wpt_hit(wpt_hit),
        .step_req(step_req), .hist_done(hist_done), .halt_o(halt_o),
        .irq_inhibit_o(irq_inhibit_o), .trap_en_o(trap_en_o),
        .hist_en_o(hist_en_o), .hist_cont_o(hist_cont_o),
        .step_toggle_o(step_toggle_o), .ctl_q(ctl_q), .status_q(status_q)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic m_flag();
        return (|(cpu_flags & msm)) || (|(~cpu_flags & mcm));
    endfunction

    function automatic logic m_halt();
        return mctl[0] | (brk_hit & mctl[7]) | (wpt_hit & mctl[6]) | (m_flag() & mctl[1]);
    endfunction

    function automatic logic [7:0] m_stat();
        return {mtgl, 1'b0, wpt_hit, mctl[7], mctl[6], mfs, mws, mbs};
    endfunction

    task automatic check_all();
        chk("R3 ctl", ctl_q, mctl);
        chk("R4 halt", {7'd0, halt_o}, {7'd0, m_halt()});
        chk("R6 status", status_q, m_stat());
        chk("R11 outs", {4'd0, irq_inhibit_o, hist_en_o, hist_cont_o, trap_en_o},
            {4'd0, mctl[4], mctl[2], mctl[3], mctl[5]});
        chk("R10 toggle", {7'd0, step_toggle_o}, {7'd0, mtgl});
    endtask

    task automatic model_edge();
        logic [7:0] n;
        logic fm;
        fm = m_flag();
        n  = mctl;
        if (ctl_wr) n = ctl_wdata;
        if (mask_wr) begin n[1] = 1'b1; msm = mask_set; mcm = mask_clr; end
        if (hist_done && !mctl[3]) n[2] = 1'b0;
        n[5] = 1'b1;
        mbs  = (brk_hit & mctl[7]) | (mbs & ~ctl_wr);
        mws  = (wpt_hit & mctl[6]) | (mws & ~ctl_wr);
        mfs  = (fm & mctl[1])      | (mfs & ~ctl_wr);
        mtgl = mtgl ^ step_req;
        mctl = n;
    endtask

    // caller drives inputs at the falling edge and waits #1 first
    task automatic cyc();
        check_all();
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic idle();
        ctl_wr = 0; mask_wr = 0; brk_hit = 0; wpt_hit = 0; step_req = 0;
        hist_done = 0; ctl_wdata = 0; mask_set = 0; mask_clr = 0; cpu_flags = 0;
    endtask

    task automatic wr_ctl(input logic [7:0] v);
        ctl_wr = 1; ctl_wdata = v; #1; cyc(); ctl_wr = 0; #1;
    endtask

    initial begin
        logic t0;
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'h5EED_1234);
        rst = 1; idle();
        repeat (3) @(negedge clk);
        rst = 0;
        mctl = 8'h20; msm = 0; mcm = 0; mbs = 0; mws = 0; mfs = 0; mtgl = 0;
        #1;
        chk("R2 ctl reset", ctl_q, 8'h20);
        chk("R2 status reset", status_q, 8'h00);
        cyc();

        // R3: bit 5 forced
        wr_ctl(8'h00);
        chk("R3 trap fixed", ctl_q, 8'h20);
        cyc();

        // R1: trace halts, then resume
        wr_ctl(8'h01);
        chk("R1 trace halt", {7'd0, halt_o}, 8'd1);
        cyc();
        wr_ctl(8'h00);
        chk("R1 resume", {7'd0, halt_o}, 8'd0);
        cyc();

        // R4/R6: disabled breakpoint
        brk_hit = 1; #1;
        chk("R4 disabled brk", {7'd0, halt_o}, 8'd0);
        cyc(); brk_hit = 0; #1;
        chk("R6 disabled no status", {7'd0, status_q[0]}, 8'd0);
        cyc();

        // R4/R6/R7: enabled breakpoint, sticky, cleared by write
        wr_ctl(8'h80);
        brk_hit = 1; #1;
        chk("R4 enabled brk", {7'd0, halt_o}, 8'd1);
        cyc(); brk_hit = 0; #1;
        chk("R6 brk status", {7'd0, status_q[0]}, 8'd1);
        cyc(); #1;
        chk("R7 sticky", {7'd0, status_q[0]}, 8'd1);
        wr_ctl(8'h80);
        chk("R7 cleared by write", {7'd0, status_q[0]}, 8'd0);
        cyc();

        // R5: mask load and both mask kinds
        mask_wr = 1; mask_set = 8'h04; mask_clr = 8'h00; #1; cyc();
        mask_wr = 0; #1;
        chk("R5 mask sets enable", {7'd0, ctl_q[1]}, 8'd1);
        cpu_flags = 8'h04; #1;
        chk("R5 set-mask match", {7'd0, halt_o}, 8'd1);
        cyc();
        mask_wr = 1; mask_set = 8'h00; mask_clr = 8'h10; cpu_flags = 8'hFF; #1; cyc();
        mask_wr = 0; #1;
        chk("R5 no clear match", {7'd0, halt_o}, 8'd0);
        cpu_flags = 8'hEF; #1;
        chk("R5 clear-mask match", {7'd0, halt_o}, 8'd1);
        cyc(); cpu_flags = 8'h00;

        // R8: mirrors and raw watchpoint
        wpt_hit = 1; #1;
        chk("R8 raw wpt", {7'd0, status_q[5]}, 8'd1);
        chk("R8 bit6 zero", {7'd0, status_q[6]}, 8'd0);
        chk("R8 mirrors", {6'd0, status_q[4:3]}, {6'd0, ctl_q[7:6]});
        cyc(); wpt_hit = 0; #1; cyc();

        // R9: history clear
        wr_ctl(8'h04);
        hist_done = 1; #1; cyc(); hist_done = 0; #1;
        chk("R9 hist cleared", {7'd0, ctl_q[2]}, 8'd0);
        wr_ctl(8'h0C);
        hist_done = 1; #1; cyc(); hist_done = 0; #1;
        chk("R9 continuous kept", {7'd0, ctl_q[2]}, 8'd1);
        wr_ctl(8'h00);
        ctl_wr = 1; ctl_wdata = 8'h04; hist_done = 1; #1; cyc();
        ctl_wr = 0; hist_done = 0; #1;
        chk("R9 overrides write", {7'd0, ctl_q[2]}, 8'd0);

        // R10 / R11
        t0 = status_q[7];
        step_req = 1; #1; cyc(); step_req = 0; #1;
        chk("R10 step flips", {7'd0, status_q[7]}, {7'd0, ~t0});
        wr_ctl(8'h10);
        chk("R11 irq inhibit", {7'd0, irq_inhibit_o}, 8'd1);
        cyc();

        // random mix
        for (int i = 0; i < 4000; i++) begin
            ctl_wr    = ($urandom % 8) == 0;
            ctl_wdata = 8'($urandom);
            mask_wr   = ($urandom % 16) == 0;
            mask_set  = FW'($urandom) & FW'($urandom);
            mask_clr  = FW'($urandom) & FW'($urandom);
            cpu_flags = FW'($urandom);
            brk_hit   = ($urandom % 4) == 0;
            wpt_hit   = ($urandom % 4) == 0;
            step_req  = ($urandom % 4) == 0;
            hist_done = ($urandom % 16) == 0;
            #1;
            cyc();
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule